// File: doc/BRIEF.md
# Decimal Adjust Unit for Multiply and Divide

This block carries out the two byte-wide decimal adjust operations of a small processor core. Each acts on an 8-bit high/low register pair. The core presents an opcode byte, an immediate byte and the current high and low register values for one cycle. The unit then writes new high and low values back, together with sign, zero and parity flags computed from the new low value, and pulses `done`.

- **Multiply-adjust form.** The low register is split by the immediate. The quotient goes to the high register and the remainder to the low register. A restoring divider produces this result one quotient bit per clock.
- **Divide-adjust form.** The high register is multiplied by a base and added to the low register. The result is truncated to the low register width and written to the low register, and the high register is cleared.

A build-time parameter picks the variant of the divide-adjust form. In one variant it takes its base from the immediate byte. In the other it always uses ten and ignores the immediate byte. Both variants exist in deployed cores.

The usual encoding carries 0Ah as the immediate, which gives ordinary decimal behaviour. Other immediates change the base. A zero divisor on the multiply-adjust form leaves the registers as they were and flags a divide error, which the core turns into its trap.

Top module: `ascii_adj_unit`

## Requirements
- R1: During and after synchronous reset, `busy`, `done`, `div_err`, `ah_out`, `al_out`, `sf`, `zf` and `pf` are all zero.
- R2: For opcode D4h with a nonzero immediate, `ah_out` becomes `req_al / req_imm` and `al_out` becomes `req_al % req_imm`.
  - Example: AL=55h with immediate 0Ah gives AH=08h, AL=05h.
  - Example: AL=55h with immediate 10h gives AH=05h, AL=05h.
- R3: For opcode D4h with a nonzero immediate, the unit spends one clock per quotient bit. `done` rises DATA_W+1 clock edges after the accepting edge. `done` is high for exactly one cycle for every operation.
- R4: For opcode D4h with immediate 00h, `done` and `div_err` rise together one edge after acceptance. The outputs are `ah_out=req_ah` and `al_out=req_al`, and the flags come from that unchanged low value. `div_err` is never high otherwise.
- R5: For opcode D5h, `done` rises one edge after acceptance. At that point `al_out = (req_ah * base + req_al) mod 2^DATA_W` and `ah_out = 0`.
- R6: The base for D5h depends on FIXED_TEN.
  - With FIXED_TEN=0 the base is `req_imm`.
  - With FIXED_TEN=1 the base is always ten and `req_imm` has no effect on the result.
- R7: With every `done` the flags are loaded from the new `al_out`:
  - `sf` is its top bit;
  - `zf` is 1 when it is zero;
  - `pf` is 1 when it holds an even number of one bits.
- R8: A request is accepted only while `busy` is low. `busy` is high from the edge after acceptance until the edge that raises `done`. A request presented while busy is dropped and does not change the result of the running operation.
- R9: A request whose opcode is neither D4h nor D5h is ignored: `busy` and `done` stay low.
- R10: `ah_out`, `al_out` and the flags hold their values in every cycle in which `done` is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_opcode | input | 8 | Operation opcode (D4h or D5h) |
| req_imm | input | DATA_W | Immediate byte: divisor or base |
| req_ah | input | DATA_W | Current high register value |
| req_al | input | DATA_W | Current low register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Zero divisor on D4h, valid with done |
| ah_out | output | DATA_W | New high register value |
| al_out | output | DATA_W | New low register value |
| sf | output | 1 | Sign of new low value |
| zf | output | 1 | New low value is zero |
| pf | output | 1 | Even parity of new low value |

## Verification
The bench builds two copies side by side with DATA_W=8. One has FIXED_TEN=0 and the other FIXED_TEN=1, and both receive the same requests on every cycle. D5h requests with immediates other than 0Ah therefore show the two variants diverging in the same run. Requests with 0Ah show them agreeing, and the multiply-adjust path is checked to be identical in both. The 8-bit width keeps exhaustive-style corner operands in reach: FFh dividends, divisor FFh, divisor 01h, and D5h products that wrap past 256.

// File: rtl/adj_pkg.sv
package adj_pkg;
  localparam logic [7:0] OPC_MUL_ADJ = 8'hD4;
  localparam logic [7:0] OPC_DIV_ADJ = 8'hD5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } adj_state_t;
endpackage

// File: rtl/adj_divider.sv
// Restoring divider: one quotient bit per clock, fin pulses after the last bit.
module adj_divider #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic [DATA_W-1:0] quotient,
  output logic [DATA_W-1:0] remainder,
  output logic              fin
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] dsr_q;
  logic [DATA_W:0]   shifted;
  logic [DATA_W:0]   trial;

  assign shifted = {remainder, quotient[DATA_W-1]};
  assign trial   = shifted - {1'b0, dsr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      dsr_q     <= '0;
      quotient  <= '0;
      remainder <= '0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        run_q     <= 1'b1;
        cnt_q     <= '0;
        dsr_q     <= divisor;
        quotient  <= dividend;
        remainder <= '0;
      end else if (run_q) begin
        if (trial[DATA_W]) begin
          remainder <= shifted[DATA_W-1:0];
          quotient  <= {quotient[DATA_W-2:0], 1'b0};
        end else begin
          remainder <= trial[DATA_W-1:0];
          quotient  <= {quotient[DATA_W-2:0], 1'b1};
        end
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adj_mac.sv
// Multiply-accumulate for the divide-adjust form; variant picks the base source.
module adj_mac #(
  parameter int DATA_W    = 8,
  parameter bit FIXED_TEN = 1'b0
) (
  input  logic [DATA_W-1:0] base_imm,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0]   base;
  logic [2*DATA_W-1:0] full;

  generate
    if (FIXED_TEN) begin : g_ten
      assign base = DATA_W'(10);
    end else begin : g_imm
      assign base = base_imm;
    end
  endgenerate

  assign full = ({{DATA_W{1'b0}}, hi} * {{DATA_W{1'b0}}, base})
              + {{DATA_W{1'b0}}, lo};
  assign res  = full[DATA_W-1:0];
endmodule

// File: rtl/adj_flags.sv
module adj_flags #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val,
  output logic              sign,
  output logic              zero,
  output logic              par_even
);
  assign sign     = val[DATA_W-1];
  assign zero     = (val == '0);
  assign par_even = ~^val;
endmodule

// File: rtl/ascii_adj_unit.sv
module ascii_adj_unit
  import adj_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter bit FIXED_TEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        req_opcode,
  input  logic [DATA_W-1:0] req_imm,
  input  logic [DATA_W-1:0] req_ah,
  input  logic [DATA_W-1:0] req_al,
  output logic              busy,
  output logic              done,
  output logic              div_err,
  output logic [DATA_W-1:0] ah_out,
  output logic [DATA_W-1:0] al_out,
  output logic              sf,
  output logic              zf,
  output logic              pf
);
  adj_state_t state_q;
  logic is_mul, is_dadj, accept, zero_imm;
  logic zero_q;
  logic [DATA_W-1:0] ah_q, al_q, imm_q;
  logic [DATA_W-1:0] quo, rem, mac_res;
  logic fin;
  logic wr_en;
  logic [DATA_W-1:0] ah_nxt, al_nxt;
  logic sf_n, zf_n, pf_n;

  assign is_mul   = (req_opcode == OPC_MUL_ADJ);
  assign is_dadj  = (req_opcode == OPC_DIV_ADJ);
  assign zero_imm = (req_imm == '0);
  assign accept   = req_valid && (state_q == ST_IDLE) && (is_mul || is_dadj);
  assign busy     = (state_q != ST_IDLE);

  adj_divider #(.DATA_W(DATA_W)) u_div (
    .clk(clk), .rst(rst),
    .start(accept && is_mul && !zero_imm),
    .dividend(req_al), .divisor(req_imm),
    .quotient(quo), .remainder(rem), .fin(fin)
  );

  adj_mac #(.DATA_W(DATA_W), .FIXED_TEN(FIXED_TEN)) u_mac (
    .base_imm(imm_q), .hi(ah_q), .lo(al_q), .res(mac_res)
  );

  always_comb begin
    wr_en  = 1'b0;
    ah_nxt = ah_out;
    al_nxt = al_out;
    case (state_q)
      ST_DIV: begin
        if (fin) begin
          wr_en  = 1'b1;
          ah_nxt = quo;
          al_nxt = rem;
        end
      end
      ST_FIN: begin
        wr_en = 1'b1;
        if (zero_q) begin
          ah_nxt = ah_q;
          al_nxt = al_q;
        end else begin
          ah_nxt = '0;
          al_nxt = mac_res;
        end
      end
      default: ;
    endcase
  end

  adj_flags #(.DATA_W(DATA_W)) u_flags (
    .val(al_nxt), .sign(sf_n), .zero(zf_n), .par_even(pf_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      zero_q  <= 1'b0;
      ah_q    <= '0;
      al_q    <= '0;
      imm_q   <= '0;
      done    <= 1'b0;
      div_err <= 1'b0;
      ah_out  <= '0;
      al_out  <= '0;
      sf      <= 1'b0;
      zf      <= 1'b0;
      pf      <= 1'b0;
    end else begin
      done    <= 1'b0;
      div_err <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            ah_q    <= req_ah;
            al_q    <= req_al;
            imm_q   <= req_imm;
            zero_q  <= is_mul && zero_imm;
            state_q <= (is_mul && !zero_imm) ? ST_DIV : ST_FIN;
          end
        end
        ST_DIV: if (fin) state_q <= ST_IDLE;
        ST_FIN: begin
          state_q <= ST_IDLE;
          div_err <= zero_q;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (wr_en) begin
        ah_out <= ah_nxt;
        al_out <= al_nxt;
        sf     <= sf_n;
        zf     <= zf_n;
        pf     <= pf_n;
        done   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adj_unit_chk.sv
module adj_unit_chk
  import adj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [7:0]        req_opcode,
  input logic [DATA_W-1:0] req_imm,
  input logic              busy,
  input logic              done,
  input logic              div_err,
  input logic [DATA_W-1:0] ah_out,
  input logic [DATA_W-1:0] al_out,
  input logic              sf,
  input logic              zf
);
  logic known, acc, mul_q;
  logic [DATA_W-1:0] imm_q;
  logic [15:0] cnt_q;

  assign known = (req_opcode == OPC_MUL_ADJ) || (req_opcode == OPC_DIV_ADJ);
  assign acc   = req_valid && !busy && known;

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_q <= 1'b0;
      imm_q <= '0;
      cnt_q <= '0;
    end else if (acc) begin
      mul_q <= (req_opcode == OPC_MUL_ADJ);
      imm_q <= req_imm;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + 16'd1;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (done && mul_q && !div_err) |-> (cnt_q == 16'(DATA_W + 1)));
  p_rem_below_r2: assert property (@(posedge clk) disable iff (rst)
    (done && mul_q && !div_err) |-> (al_out < imm_q));
  p_err_zero_r4: assert property (@(posedge clk) disable iff (rst)
    div_err |-> (done && mul_q && imm_q == '0));
  p_hi_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !mul_q) |-> (ah_out == '0));
  p_zf_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (zf == (al_out == '0)));
  p_sf_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (sf == al_out[DATA_W-1]));
  p_busy_accept_r8: assert property (@(posedge clk) disable iff (rst)
    acc |=> busy);
  p_unknown_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && !known) |=> !busy);
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(ah_out) && $stable(al_out)));
endmodule

bind ascii_adj_unit adj_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
  .req_imm(req_imm), .busy(busy), .done(done), .div_err(div_err),
  .ah_out(ah_out), .al_out(al_out), .sf(sf), .zf(zf)
);

// File: tb/ascii_adj_unit_tb_top.sv
`timescale 1ns/1ps
module ascii_adj_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0] req_opcode = 8'h00;
  logic [7:0] req_imm = 8'h00;
  logic [7:0] req_ah = 8'h00;
  logic [7:0] req_al = 8'h00;

  logic busy_i, done_i, err_i, sf_i, zf_i, pf_i;
  logic [7:0] ah_i, al_i;
  logic busy_t, done_t, err_t, sf_t, zf_t, pf_t;
  logic [7:0] ah_t, al_t;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  ascii_adj_unit #(.DATA_W(8), .FIXED_TEN(1'b0)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_imm(req_imm), .req_ah(req_ah), .req_al(req_al),
    .busy(busy_i), .done(done_i), .div_err(err_i), .ah_out(ah_i),
    .al_out(al_i), .sf(sf_i), .zf(zf_i), .pf(pf_i));

  ascii_adj_unit #(.DATA_W(8), .FIXED_TEN(1'b1)) dut_t (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_imm(req_imm), .req_ah(req_ah), .req_al(req_al),
    .busy(busy_t), .done(done_t), .div_err(err_t), .ah_out(ah_t),
    .al_out(al_t), .sf(sf_t), .zf(zf_t), .pf(pf_t));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dadj(input logic [7:0] ah, al, base);
    dadj = 8'((16'(ah) * 16'(base)) + 16'(al));
  endfunction

  // Issue one request, wait for done on dut_i, check both copies.
  task automatic run_op(input logic [7:0] op, imm, ah, al, input bit inject);
    int lat;
    logic [7:0] e_ah, e_al, e_ah_t, e_al_t;
    logic e_err;
    int e_lat;
    if (op == 8'hD4) begin
      if (imm == 8'h00) begin
        e_ah = ah; e_al = al; e_err = 1'b1; e_lat = 1;
      end else begin
        e_ah = al / imm; e_al = al % imm; e_err = 1'b0; e_lat = 9;
      end
      e_ah_t = e_ah; e_al_t = e_al;
    end else begin
      e_ah = 8'h00; e_al = dadj(ah, al, imm); e_err = 1'b0; e_lat = 1;
      e_ah_t = 8'h00; e_al_t = dadj(ah, al, 8'd10);
    end
    @(negedge clk);
    req_opcode = op; req_imm = imm; req_ah = ah; req_al = al; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 busy after accept", int'(busy_i), 1);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (inject && lat == 3) begin
        req_opcode = 8'hD5; req_imm = 8'h33; req_ah = 8'h77; req_al = 8'h11;
        req_valid = 1'b1;
      end
      if (inject && lat == 4) req_valid = 1'b0;
    end while (!done_i && lat < 60);
    chk("R3 latency", lat, e_lat);
    chk(op == 8'hD4 ? "R2 ah" : "R5 ah", int'(ah_i), int'(e_ah));
    chk(op == 8'hD4 ? "R2 al" : "R6 al base imm", int'(al_i), int'(e_al));
    chk("R4 div_err", int'(err_i), int'(e_err));
    chk("R7 sf", int'(sf_i), int'(e_al[7]));
    chk("R7 zf", int'(zf_i), int'(e_al == 8'h00));
    chk("R7 pf", int'(pf_i), int'(~^e_al));
    chk("R6 ah fixed ten", int'(ah_t), int'(e_ah_t));
    chk("R6 al fixed ten", int'(al_t), int'(e_al_t));
    chk("R6 done fixed ten", int'(done_t), 1);
    @(negedge clk);
    chk("R3 done single cycle", int'(done_i), 0);
    chk("R8 idle after done", int'(busy_i), 0);
    chk("R10 al held", int'(al_i), int'(e_al));
    chk("R10 ah held", int'(ah_i), int'(e_ah));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL R3 watchdog expired actual=hung expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] h0, l0;
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    chk("R1 busy reset", int'(busy_i), 0);
    chk("R1 done reset", int'(done_i), 0);
    chk("R1 outputs reset", int'({err_i, sf_i, zf_i, pf_i, ah_i, al_i}), 0);
    @(negedge clk);
    rst = 1'b0;

    run_op(8'hD4, 8'h0A, 8'h00, 8'h55, 1'b0); // R2 decimal split
    run_op(8'hD4, 8'h10, 8'h00, 8'h55, 1'b0); // R2 base sixteen
    run_op(8'hD4, 8'h00, 8'h12, 8'h34, 1'b0); // R4 zero divisor
    run_op(8'hD4, 8'h01, 8'h00, 8'hFF, 1'b0);
    run_op(8'hD4, 8'hFF, 8'h00, 8'hFF, 1'b0);
    run_op(8'hD4, 8'hFF, 8'h00, 8'hFE, 1'b0);
    run_op(8'hD5, 8'h0A, 8'h07, 8'h03, 1'b0); // R5 standard
    run_op(8'hD5, 8'h07, 8'h05, 8'h02, 1'b0); // R6 variants diverge
    run_op(8'hD5, 8'hFF, 8'hFF, 8'hFF, 1'b0); // R5 wrap
    run_op(8'hD5, 8'h00, 8'h00, 8'h00, 1'b0); // R7 zero result
    run_op(8'hD4, 8'h0A, 8'h00, 8'hC8, 1'b1); // R8 request while busy

    // R9: unknown opcode is ignored
    h0 = ah_i; l0 = al_i;
    @(negedge clk);
    req_opcode = 8'h90; req_imm = 8'h05; req_ah = 8'h44; req_al = 8'h99;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 not busy", int'(busy_i), 0);
    begin
      int seen = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (done_i || busy_i) seen++;
      end
      chk("R9 no done", seen, 0);
    end
    chk("R9 ah unchanged", int'(ah_i), int'(h0));
    chk("R9 al unchanged", int'(al_i), int'(l0));

    for (int n = 0; n < 200; n++) begin
      logic [7:0] op, imm;
      op  = ($urandom % 2) ? 8'hD4 : 8'hD5;
      imm = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
      run_op(op, imm, 8'($urandom), 8'($urandom), 1'b0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule